// File: doc/BRIEF.md
# Cascaded Microsecond Timebase with Two-Stage Deadline Compare

This block keeps a free-running 32-bit time value made of two 16-bit halves. A prescaler turns the core clock into a slow tick, normally one per microsecond. The low half advances on every tick. The high half advances once each time the low half rolls over. When the full 32-bit value rolls over, an overflow status bit is set. That bit also drives an overflow interrupt line.

A deadline can be armed against this time. If the deadline's upper half lies ahead of the high count, only the high-half compare is enabled. When the high half reaches the deadline, the block hands over to the low-half compare by itself. If the upper halves are already equal, the low-half compare is enabled directly. A deadline that is already behind the current time never fires. When the deadline is reached, an event status bit is set and the event interrupt rises.

Software can do three more things:
- Load a new time. This also clears all status and disarms any compare.
- Disarm a pending compare.
- Clear status bits by writing a zero to them.

The time output is taken from both half registers in the same cycle, so a read is never torn.

Top module: `split_timebase`

## Requirements
- R1: While reset is held, the time reads 0, and both status bits and both interrupts are 0. After reset, the time advances once per clock until the first load.
- R2: A divisor value P makes the time advance once every P+1 clocks. P is taken in only on a load or when the low half rolls from 0xFFFF to 0x0000. A change of P in the middle of a low-half period has no effect until that rollover.
- R3: The high half increments exactly when the low half rolls from 0xFFFF to 0x0000. Apart from a load, the time changes by 0 or +1 per clock.
- R4: When the time rolls from 0xFFFFFFFF to 0x00000000, status bit 1 (overflow) and the overflow interrupt are set in the same clock.
- R5: A load places the given value on the time output at the next clock. It clears both status bits, disarms both compares and restarts the prescaler period.
- R6: An armed deadline whose upper half is greater than the high count sets status bit 0 (event) and raises the event interrupt one clock after the time equals the deadline. This includes a deadline whose low half is 0x0000.
- R7: An armed deadline whose upper half equals the high count fires one clock after the time equals the deadline.
- R8: An armed deadline that is behind the current time never sets the event bit.
- R9: The disarm strobe cancels a pending compare, so no event follows.
- R10: A status write with the strobe high clears every status bit whose data bit is 0. It leaves every status bit whose data bit is 1 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Synchronous reset, active low |
| prescaleDiv | input | 16 | Tick divisor minus one |
| loadStb | input | 1 | Load the time from loadValue |
| loadValue | input | 32 | New time value |
| armStb | input | 1 | Arm the compare with deadline |
| deadline | input | 32 | Deadline value |
| disarmStb | input | 1 | Cancel a pending compare |
| statusWrStb | input | 1 | Status write strobe |
| statusWrData | input | 2 | Bits written as 0 clear; bit 1 overflow, bit 0 event |
| timeNow | output | 32 | Coherent time {high, low} |
| statusFlags | output | 2 | Bit 1 overflow, bit 0 event |
| eventIrq | output | 1 | Deadline event interrupt |
| ovfIrq | output | 1 | Time rollover interrupt |

## Verification
The assertions take for granted that every strobe is a clean 0 or 1 once reset is released. They also assume that a deadline arm and a disarm are never requested in the same clock. They assume the event bit is never cleared by software in the clock after a match. The bench keeps within these limits:
- It changes inputs only on falling edges.
- It holds each strobe high for exactly one clock.
- It never pairs an arm with a disarm.
- It issues its status writes only at points where no compare is about to fire.

// File: rtl/split_timebase_pkg.sv
`timescale 1ns/1ps
package split_timebase_pkg;
  localparam int HALF_W = 16;
  localparam int TIME_W = 2 * HALF_W;

  // datapath view handed to control each cycle
  typedef struct packed {
    logic [HALF_W-1:0] hi;
    logic [HALF_W-1:0] lo;
    logic [HALF_W-1:0] hiNext;
    logic              hiWrap;
  } dpInfo_t;

  // strobes from control into the datapath
  typedef struct packed {
    logic load;
  } ctlCmd_t;
endpackage

// File: rtl/split_timebase_dp.sv
`timescale 1ns/1ps
module split_timebase_dp
  import split_timebase_pkg::*;
#(
  parameter int PS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlCmd_t           cmd,
  input  logic [PS_W-1:0]   prescaleDiv,
  input  logic [TIME_W-1:0] loadValue,
  output dpInfo_t           info,
  output logic [TIME_W-1:0] timeNow
);
  localparam logic [HALF_W-1:0] HALF_MAX = '1;
  localparam logic [HALF_W-1:0] HALF_ONE = HALF_W'(1);
  localparam logic [PS_W-1:0]   PS_ONE   = PS_W'(1);

  logic [HALF_W-1:0] hiCnt, loCnt;
  logic [PS_W-1:0]   psCnt, psLimit;
  logic tick, loWrap, hiWrap;

  assign tick   = !cmd.load && (psCnt == psLimit);
  assign loWrap = tick && (loCnt == HALF_MAX);
  assign hiWrap = loWrap && (hiCnt == HALF_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiCnt   <= '0;
      loCnt   <= '0;
      psCnt   <= '0;
      psLimit <= '0;
    end else if (cmd.load) begin
      hiCnt   <= loadValue[TIME_W-1:HALF_W];
      loCnt   <= loadValue[HALF_W-1:0];
      psCnt   <= '0;
      psLimit <= prescaleDiv;
    end else if (tick) begin
      psCnt <= '0;
      loCnt <= loCnt + HALF_ONE;
      if (loWrap) begin
        hiCnt   <= hiCnt + HALF_ONE;
        psLimit <= prescaleDiv;   // update event: new divisor applies here
      end
    end else begin
      psCnt <= psCnt + PS_ONE;
    end
  end

  assign timeNow     = {hiCnt, loCnt};
  assign info.hi     = hiCnt;
  assign info.lo     = loCnt;
  assign info.hiNext = cmd.load ? loadValue[TIME_W-1:HALF_W]
                     : (loWrap ? hiCnt + HALF_ONE : hiCnt);
  assign info.hiWrap = hiWrap;

  // R3: without a load the time moves by at most one step per clock
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.load |=> (timeNow == $past(timeNow)) || (timeNow == $past(timeNow) + TIME_W'(1)));

  // R2: divisor only changes on load or low-half rollover
  a_r2_divisor_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.load || loWrap) |=> $stable(psLimit));

  // R3: the high half moves only together with a low-half rollover
  a_r3_hi_follows_lo: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && !loWrap) |=> $stable(hiCnt));
endmodule

// File: rtl/split_timebase_ctl.sv
`timescale 1ns/1ps
module split_timebase_ctl
  import split_timebase_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStb,
  input  logic              armStb,
  input  logic [TIME_W-1:0] deadline,
  input  logic              disarmStb,
  input  logic              statusWrStb,
  input  logic [1:0]        statusWrData,
  input  dpInfo_t           info,
  output ctlCmd_t           cmd,
  output logic [1:0]        statusFlags
);
  logic [TIME_W-1:0] dlReg;
  logic hiCmpEn, loCmpEn, evFlag, ovFlag;
  logic hiHit, loHit, matchNow, matchOk;
  logic [HALF_W-1:0] dlHiIn;

  assign cmd.load = loadStb;
  assign dlHiIn   = deadline[TIME_W-1:HALF_W];
  assign hiHit    = info.hi == dlReg[TIME_W-1:HALF_W];
  assign loHit    = info.lo == dlReg[HALF_W-1:0];
  assign matchNow = (hiCmpEn || loCmpEn) && hiHit && loHit;
  assign matchOk  = matchNow && !armStb && !disarmStb && !loadStb;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dlReg   <= '0;
      hiCmpEn <= 1'b0;
      loCmpEn <= 1'b0;
      evFlag  <= 1'b0;
      ovFlag  <= 1'b0;
    end else begin
      // overflow status
      if (loadStb)                             ovFlag <= 1'b0;
      else if (info.hiWrap)                    ovFlag <= 1'b1;
      else if (statusWrStb && !statusWrData[1]) ovFlag <= 1'b0;
      // event status
      if (loadStb)                             evFlag <= 1'b0;
      else if (matchOk)                        evFlag <= 1'b1;
      else if (statusWrStb && !statusWrData[0]) evFlag <= 1'b0;
      // compare stage control
      if (armStb) begin
        dlReg   <= deadline;
        hiCmpEn <= dlHiIn > info.hiNext;
        loCmpEn <= dlHiIn == info.hiNext;
      end else if (loadStb || disarmStb || matchNow) begin
        hiCmpEn <= 1'b0;
        loCmpEn <= 1'b0;
      end else if (hiCmpEn && hiHit) begin
        hiCmpEn <= 1'b0;          // hand over to the low-half stage
        loCmpEn <= 1'b1;
      end else if (loCmpEn && !hiHit) begin
        loCmpEn <= 1'b0;          // low half missed within this high period
      end
    end
  end

  assign statusFlags = {ovFlag, evFlag};

  // R4: a full rollover always leaves the overflow bit set
  a_r4_ovf_set: assert property (@(posedge clk) disable iff (!rstN)
    (info.hiWrap && !loadStb) |=> ovFlag);

  // R6: at most one compare stage is live
  a_r6_one_stage: assert property (@(posedge clk) disable iff (!rstN)
    !(hiCmpEn && loCmpEn));

  // R8: an event only rises right after the time equalled the deadline
  a_r8_exact_fire: assert property (@(posedge clk) disable iff (!rstN)
    $rose(evFlag) |-> ($past({info.hi, info.lo}) == $past(dlReg)));

  // R9: disarm leaves no stage enabled
  a_r9_disarm: assert property (@(posedge clk) disable iff (!rstN)
    (disarmStb && !armStb) |=> !hiCmpEn && !loCmpEn);

  // R5: a load clears both status bits
  a_r5_load_clears: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> (statusFlags == 2'b00));
endmodule

// File: rtl/split_timebase.sv
`timescale 1ns/1ps
module split_timebase
  import split_timebase_pkg::*;
#(
  parameter int PS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PS_W-1:0]   prescaleDiv,
  input  logic              loadStb,
  input  logic [TIME_W-1:0] loadValue,
  input  logic              armStb,
  input  logic [TIME_W-1:0] deadline,
  input  logic              disarmStb,
  input  logic              statusWrStb,
  input  logic [1:0]        statusWrData,
  output logic [TIME_W-1:0] timeNow,
  output logic [1:0]        statusFlags,
  output logic              eventIrq,
  output logic              ovfIrq
);
  dpInfo_t info;
  ctlCmd_t cmd;

  split_timebase_dp #(.PS_W(PS_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .prescaleDiv(prescaleDiv),
    .loadValue(loadValue), .info(info), .timeNow(timeNow)
  );

  split_timebase_ctl u_ctl (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .armStb(armStb),
    .deadline(deadline), .disarmStb(disarmStb), .statusWrStb(statusWrStb),
    .statusWrData(statusWrData), .info(info), .cmd(cmd),
    .statusFlags(statusFlags)
  );

  assign eventIrq = statusFlags[0];
  assign ovfIrq   = statusFlags[1];
endmodule

// File: tb/split_timebase_tb.sv
`timescale 1ns/1ps
module split_timebase_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] prescaleDiv = '0;
  logic        loadStb = 1'b0;
  logic [31:0] loadValue = '0;
  logic        armStb = 1'b0;
  logic [31:0] deadline = '0;
  logic        disarmStb = 1'b0;
  logic        statusWrStb = 1'b0;
  logic [1:0]  statusWrData = '0;
  logic [31:0] timeNow;
  logic [1:0]  statusFlags;
  logic        eventIrq, ovfIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  split_timebase u_dut (
    .clk(clk), .rstN(rstN), .prescaleDiv(prescaleDiv), .loadStb(loadStb),
    .loadValue(loadValue), .armStb(armStb), .deadline(deadline),
    .disarmStb(disarmStb), .statusWrStb(statusWrStb),
    .statusWrData(statusWrData), .timeNow(timeNow),
    .statusFlags(statusFlags), .eventIrq(eventIrq), .ovfIrq(ovfIrq)
  );

  typedef struct packed {
    logic [15:0] ps;
    logic [31:0] start;
    logic [15:0] cycles;
    logic [31:0] expTime;
    logic        expOvf;
  } vec_t;

  // R2/R3/R4 vectors: divisor, start, clocks after load, expected time, overflow
  localparam vec_t VECS [6] = '{
    '{16'd0, 32'h0000_0010, 16'd20, 32'h0000_0024, 1'b0},
    '{16'd0, 32'h0000_FFFE, 16'd3,  32'h0001_0001, 1'b0},
    '{16'd0, 32'hFFFF_FFFE, 16'd4,  32'h0000_0002, 1'b1},
    '{16'd3, 32'h0000_1000, 16'd10, 32'h0000_1002, 1'b0},
    '{16'd4, 32'h1234_FFFF, 16'd5,  32'h1235_0000, 1'b0},
    '{16'd1, 32'h7FFF_FFFF, 16'd7,  32'h8000_0002, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doLoad(input logic [15:0] ps, input logic [31:0] val);
    prescaleDiv = ps; loadValue = val; loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  task automatic doArm(input logic [31:0] dl);
    deadline = dl; armStb = 1'b1;
    @(negedge clk);
    armStb = 1'b0;
  endtask

  task automatic doStatusWr(input logic [1:0] d);
    statusWrData = d; statusWrStb = 1'b1;
    @(negedge clk);
    statusWrStb = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    step(3);
    check("R1 time in reset", timeNow, 32'h0);
    check("R1 status in reset", {30'd0, statusFlags}, 32'h0);
    check("R1 irqs in reset", {30'd0, eventIrq, ovfIrq}, 32'h0);
    rstN = 1'b1;
    step(5);
    check("R1 counts once per clock after reset", timeNow, 32'd5);

    for (int i = 0; i < 6; i++) begin
      doLoad(VECS[i].ps, VECS[i].start);
      step(int'(VECS[i].cycles));
      check("R2 R3 vector time", timeNow, VECS[i].expTime);
      check("R4 vector overflow irq", {31'd0, ovfIrq}, {31'd0, VECS[i].expOvf});
    end

    // R11-style divisor change: R2 new divisor waits for low rollover
    doLoad(16'd3, 32'h0000_FFFE);
    prescaleDiv = 16'd0;
    step(6);
    check("R2 divisor held mid-period", timeNow, 32'h0000_FFFF);
    step(4);
    check("R2 divisor applied after rollover", timeNow, 32'h0001_0002);

    // R5 and R10 on the overflow bit
    doLoad(16'd0, 32'hFFFF_FFFF);
    step(1);
    check("R4 overflow bit after rollover", {30'd0, statusFlags}, 32'h2);
    doStatusWr(2'b11);
    check("R10 write one keeps overflow", {30'd0, statusFlags}, 32'h2);
    doStatusWr(2'b01);
    check("R10 write zero clears overflow", {30'd0, statusFlags}, 32'h0);
    doLoad(16'd0, 32'hFFFF_FFFF);
    step(1);
    doLoad(16'd0, 32'h0000_0005);
    check("R5 load value visible", timeNow, 32'h5);
    check("R5 load clears status", {30'd0, statusFlags}, 32'h0);

    // R6 high-half stage then low-half stage
    doLoad(16'd0, 32'h0001_FFF0);
    doArm(32'h0002_0005);
    step(20);
    check("R6 time at deadline", timeNow, 32'h0002_0005);
    check("R6 no event yet", {31'd0, eventIrq}, 32'h0);
    step(1);
    check("R6 event one clock after deadline", {31'd0, eventIrq}, 32'h1);

    // R6 hand-over with a zero low half
    doLoad(16'd0, 32'h0007_FFFA);
    doArm(32'h0008_0000);
    step(5);
    check("R6 zero-low no early event", {31'd0, eventIrq}, 32'h0);
    step(1);
    check("R6 zero-low event", {31'd0, eventIrq}, 32'h1);

    // R7 upper halves already equal
    doLoad(16'd0, 32'h0003_0000);
    doArm(32'h0003_0008);
    step(7);
    check("R7 no early event", {31'd0, eventIrq}, 32'h0);
    step(1);
    check("R7 event at deadline", {30'd0, statusFlags}, 32'h1);
    doStatusWr(2'b10);
    check("R10 write zero clears event", {30'd0, statusFlags}, 32'h0);

    // R8 deadline already behind
    doLoad(16'd0, 32'h0005_0100);
    doArm(32'h0005_0010);
    step(100);
    check("R8 past deadline no event", {31'd0, eventIrq}, 32'h0);

    // R9 disarm before the match
    doLoad(16'd0, 32'h0006_0000);
    doArm(32'h0006_0040);
    disarmStb = 1'b1;
    @(negedge clk);
    disarmStb = 1'b0;
    step(100);
    check("R9 disarmed compare no event", {31'd0, eventIrq}, 32'h0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule